// File: doc/BRIEF.md
# Smallest-Time-to-Leave Grant Scheduler

This block makes the per-slot matching decision for an N×N input-queued cell switch in which every output owns M small output queues. At the start of each slot every input presents, for each of its per-output virtual queues, a valid flag and the time-to-leave stamp of the head cell. Every output presents one availability bit per output queue. For each output on its own, the block ranks the valid requests by time-to-leave and hands the free output queues to the most urgent requests. It returns, for every (output, input) pair, either the number of the output queue the cell must be written into or a no-grant code.

Each output can take up to M cells in one slot, one per free queue. One input may win at several outputs in the same slot, so the result is a many-to-many match found in a single pass. Ranking is done by pairwise comparison. A request's rank is the number of valid requests in the same output row that beat it, and it is granted when that rank is below the row's free-queue count. The rank then picks the queue: rank r gets the r-th lowest-indexed free queue.

The decision is registered on the slot-start strobe. The grant table and the per-output free counts hold their values until the next strobe, and the availability bits of the next slot come in fresh with that next strobe.

Top module: `stcf_sched`

## Requirements
- R1: After synchronous reset, `grant_valid` is 0, every grant code is all ones, and every per-output free count in `free_total` equals M.
- R2: `grant_valid` is 1 in exactly the cycle after a cycle with `slot_start` high, and 0 otherwise. The grant codes and free counts decided on a strobe hold until the next strobe.
- R3: A pair whose request valid bit (`req_valid[j*N+i]`, output j, input i) was 0 at the strobe receives the no-grant code, all ones, whatever its time-to-leave field.
- R4: The number of grants in output row j equals the smaller of that row's valid-request count and its free-queue count. `free_total[j*CW +: CW]` equals the number of ones among that row's availability bits at the strobe.
- R5: Within a row, requests with a smaller time-to-leave (`req_tl[(j*N+i)*TL_W +: TL_W]`, unsigned) are served first. No ungranted valid request in a row has a smaller stamp than a granted one.
- R6: When two valid requests in a row carry equal stamps, the one from the lower input index ranks first.
- R7: A grant code is k+1 for output queue k (0 to M-1), where queue k of output j is free when `q_free[j*M+k]` is 1. Codes are GW bits wide, the smallest width with 2^GW ≥ M+2, and all ones means no grant.
- R8: The request ranked r-th in a row (counting from 0) receives the r-th lowest-indexed free queue of that row. No queue that was busy is granted, and no queue number appears twice in a row.
- R9: Request, stamp and availability inputs in cycles without `slot_start` have no effect: grant codes and free counts stay unchanged, and `grant_valid` stays 0.
- R10: Rows are matched independently. One input may be granted at several outputs in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Slot strobe; inputs are sampled in this cycle |
| req_valid | input | N*N | Request valid, bit j*N+i for output j, input i |
| req_tl | input | N*N*TL_W | Time-to-leave stamp per request, same ordering |
| q_free | input | N*M | Availability, bit j*M+k for queue k of output j |
| grant_valid | output | 1 | High for one cycle when a new grant table is presented |
| grant_code | output | N*N*GW | Grant per pair: queue k+1, or all ones for none |
| free_total | output | N*CW | Free-queue count per output captured at the strobe |

## Verification
A wrong rank or a wrong free-queue list shows at the ports in the grant table one cycle after the strobe that exposed it. It appears as a missing, extra, duplicated or misplaced queue number in that output's row, and the bench compares every row of every slot against a selection-based model. Sweeps over every availability mask and every valid mask, with narrow stamp ranges, force ties and full rows often enough that a tie-break or count error is exposed within a few slots. A capture error outside the strobe shows as grant codes or free counts that change while `grant_valid` is low.

// File: rtl/stcf_pkg.sv
package stcf_pkg;

    localparam int unsigned TL_MAX = 32;

    typedef logic [TL_MAX-1:0] stamp_t;

    typedef struct packed {
        logic   valid;
        stamp_t tl;
    } req_t;

    // Grant code width: codes 1..M plus an all-ones none code distinct from M.
    function automatic int unsigned code_width(input int unsigned m);
        return $clog2(m + 2);
    endfunction

    // True when request a is ranked ahead of request b in the same row.
    function automatic logic ranks_ahead(input req_t a, input req_t b, input logic a_lower);
        return a.valid && ((a.tl < b.tl) || ((a.tl == b.tl) && a_lower));
    endfunction

endpackage

// File: rtl/stcf_free_map.sv
module stcf_free_map #(
    parameter int unsigned M  = 3,
    parameter int unsigned IW = 2,
    parameter int unsigned CW = 2
) (
    input  logic [M-1:0]    free,
    output logic [M*IW-1:0] pick,
    output logic [CW-1:0]   count
);
    // pick slot q holds the index of the q-th free queue in ascending order.
    always_comb begin
        pick  = '0;
        count = '0;
        for (int k = 0; k < M; k++) begin
            if (free[k]) begin
                for (int q = 0; q < M; q++) begin
                    if (32'(count) == q) begin
                        pick[q*IW +: IW] = IW'(k);
                    end
                end
                count = count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stcf_row.sv
module stcf_row
    import stcf_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter int unsigned M    = 3,
    parameter int unsigned TL_W = 8,
    parameter int unsigned GW   = 3,
    parameter int unsigned CW   = 2
) (
    input  logic [N-1:0]      row_valid,
    input  logic [N*TL_W-1:0] row_tl,
    input  logic [M-1:0]      row_free,
    output logic [N*GW-1:0]   row_code,
    output logic [CW-1:0]     row_count
);
    localparam int unsigned IW = (M > 1) ? $clog2(M) : 1;
    localparam int unsigned RW = $clog2(N + 1);

    logic [M*IW-1:0] pick;
    req_t            reqs [N];

    stcf_free_map #(.M(M), .IW(IW), .CW(CW)) u_map (
        .free  (row_free),
        .pick  (pick),
        .count (row_count)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            reqs[i].valid = row_valid[i];
            reqs[i].tl    = stamp_t'(row_tl[i*TL_W +: TL_W]);
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_req
        logic [RW-1:0] rank;
        logic [IW-1:0] qsel;

        always_comb begin
            rank = '0;
            for (int j = 0; j < N; j++) begin
                if (j != gi && ranks_ahead(reqs[j], reqs[gi], (j < gi))) begin
                    rank = rank + 1'b1;
                end
            end
        end

        always_comb begin
            qsel = '0;
            for (int q = 0; q < M; q++) begin
                if (32'(rank) == q) begin
                    qsel = pick[q*IW +: IW];
                end
            end
        end

        always_comb begin
            if (reqs[gi].valid && (32'(rank) < 32'(row_count))) begin
                row_code[gi*GW +: GW] = GW'(qsel) + GW'(1);
            end else begin
                row_code[gi*GW +: GW] = '1;
            end
        end
    end
endmodule

// File: rtl/stcf_sched.sv
module stcf_sched
    import stcf_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter int unsigned M    = 3,
    parameter int unsigned TL_W = 8,
    localparam int unsigned GW  = code_width(M),
    localparam int unsigned CW  = $clog2(M + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slot_start,
    input  logic [N*N-1:0]        req_valid,
    input  logic [N*N*TL_W-1:0]   req_tl,
    input  logic [N*M-1:0]        q_free,
    output logic                  grant_valid,
    output logic [N*N*GW-1:0]     grant_code,
    output logic [N*CW-1:0]       free_total
);
    logic [N*N*GW-1:0] code_next;
    logic [N*CW-1:0]   count_next;

    for (genvar gj = 0; gj < N; gj++) begin : g_row
        stcf_row #(.N(N), .M(M), .TL_W(TL_W), .GW(GW), .CW(CW)) u_row (
            .row_valid (req_valid[gj*N +: N]),
            .row_tl    (req_tl[gj*N*TL_W +: N*TL_W]),
            .row_free  (q_free[gj*M +: M]),
            .row_code  (code_next[gj*N*GW +: N*GW]),
            .row_count (count_next[gj*CW +: CW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_code  <= '1;
            for (int j = 0; j < N; j++) begin
                free_total[j*CW +: CW] <= CW'(M);
            end
        end else begin
            grant_valid <= slot_start;
            if (slot_start) begin
                grant_code <= code_next;
                free_total <= count_next;
            end
        end
    end
endmodule

// File: rtl/stcf_sched_chk.sv
module stcf_sched_chk #(
    parameter int unsigned N    = 4,
    parameter int unsigned M    = 3,
    parameter int unsigned TL_W = 8,
    parameter int unsigned GW   = 3,
    parameter int unsigned CW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                slot_start,
    input logic [N*N-1:0]      req_valid,
    input logic [N*N*TL_W-1:0] req_tl,
    input logic [N*M-1:0]      q_free,
    input logic                grant_valid,
    input logic [N*N*GW-1:0]   grant_code,
    input logic [N*CW-1:0]     free_total
);
    logic [N*N-1:0] seen_valid;
    logic [N*M-1:0] seen_free;
    logic           bad_invalid, bad_queue, bad_count;

    always_ff @(posedge clk) begin
        seen_valid <= req_valid;
        seen_free  <= q_free;
    end

    always_comb begin
        bad_invalid = 1'b0;
        bad_queue   = 1'b0;
        bad_count   = 1'b0;
        for (int j = 0; j < N; j++) begin
            int unsigned used  [M];
            int unsigned nvalid, nfree, ngrant;
            nvalid = 0; nfree = 0; ngrant = 0;
            for (int k = 0; k < M; k++) begin
                used[k] = 0;
                if (seen_free[j*M+k]) nfree++;
            end
            for (int i = 0; i < N; i++) begin
                logic [GW-1:0] c;
                c = grant_code[(j*N+i)*GW +: GW];
                if (seen_valid[j*N+i]) nvalid++;
                if (c != '1) begin
                    ngrant++;
                    if (!seen_valid[j*N+i]) bad_invalid = 1'b1;
                    if (c == '0 || 32'(c) > M) begin
                        bad_queue = 1'b1;
                    end else begin
                        if (!seen_free[j*M + 32'(c) - 1]) bad_queue = 1'b1;
                        used[32'(c) - 1]++;
                    end
                end
            end
            for (int k = 0; k < M; k++) begin
                if (used[k] > 1) bad_queue = 1'b1;
            end
            if (32'(free_total[j*CW +: CW]) != nfree) bad_count = 1'b1;
            if (ngrant != ((nvalid < nfree) ? nvalid : nfree)) bad_count = 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!grant_valid && (grant_code == '1)));

    assert_strobe_to_valid_R2: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> grant_valid);

    assert_valid_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> $past(slot_start));

    assert_no_grant_invalid_R3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !bad_invalid);

    assert_grant_count_R4: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !bad_count);

    assert_free_unique_queue_R8: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !bad_queue);

    assert_hold_between_slots_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(slot_start) && !$past(rst)) |-> ($stable(grant_code) && $stable(free_total)));
endmodule

bind stcf_sched stcf_sched_chk #(.N(N), .M(M), .TL_W(TL_W), .GW(GW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_start  (slot_start),
    .req_valid   (req_valid),
    .req_tl      (req_tl),
    .q_free      (q_free),
    .grant_valid (grant_valid),
    .grant_code  (grant_code),
    .free_total  (free_total)
);

// File: tb/stcf_sched_tb.sv
module stcf_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int M    = 3;
    localparam int TL_W = 8;
    localparam int GW   = $clog2(M + 2);
    localparam int CW   = $clog2(M + 1);
    localparam logic [GW-1:0] NONE = '1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                slot_start = 1'b0;
    logic [N*N-1:0]      req_valid = '0;
    logic [N*N*TL_W-1:0] req_tl = '0;
    logic [N*M-1:0]      q_free = '0;
    logic                grant_valid;
    logic [N*N*GW-1:0]   grant_code;
    logic [N*CW-1:0]     free_total;

    int checks = 0;
    int fails  = 0;

    logic [GW-1:0] exp_code [N][N];
    int            exp_cnt  [N];

    stcf_sched #(.N(N), .M(M), .TL_W(TL_W)) u_dut (
        .clk (clk), .rst (rst), .slot_start (slot_start),
        .req_valid (req_valid), .req_tl (req_tl), .q_free (q_free),
        .grant_valid (grant_valid), .grant_code (grant_code), .free_total (free_total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Selection model: repeatedly take the most urgent unserved request.
    task automatic build_expect();
        for (int j = 0; j < N; j++) begin
            int fq [M];
            int nf;
            bit used [N];
            nf = 0;
            for (int k = 0; k < M; k++) if (q_free[j*M+k]) begin fq[nf] = k; nf++; end
            exp_cnt[j] = nf;
            for (int i = 0; i < N; i++) begin exp_code[j][i] = NONE; used[i] = 0; end
            for (int r = 0; r < nf; r++) begin
                int best;
                best = -1;
                for (int i = 0; i < N; i++) begin
                    if (req_valid[j*N+i] && !used[i]) begin
                        if (best < 0 || req_tl[(j*N+i)*TL_W +: TL_W] < req_tl[(j*N+best)*TL_W +: TL_W])
                            best = i;
                    end
                end
                if (best >= 0) begin
                    used[best] = 1;
                    exp_code[j][best] = GW'(fq[r] + 1);
                end
            end
        end
    endtask

    task automatic check_table(input string req);
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++)
                check_int(req, int'(grant_code[(j*N+i)*GW +: GW]), int'(exp_code[j][i]));
            check_int({req, " R4 count"}, int'(free_total[j*CW +: CW]), exp_cnt[j]);
        end
    endtask

    task automatic run_slot(input string req);
        build_expect();
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        check_int("R2 valid after strobe", int'(grant_valid), 1);
        check_table(req);
        @(negedge clk);
        check_int("R2 single cycle", int'(grant_valid), 0);
    endtask

    task automatic rand_inputs(input int tl_mask, input int valid_pct, input int free_pct);
        for (int c = 0; c < N*N; c++) begin
            req_valid[c] = (($urandom % 100) < valid_pct);
            req_tl[c*TL_W +: TL_W] = TL_W'($urandom & tl_mask);
        end
        for (int c = 0; c < N*M; c++) q_free[c] = (($urandom % 100) < free_pct);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_int("R1 valid", int'(grant_valid), 0);
        for (int c = 0; c < N*N; c++) check_int("R1 code", int'(grant_code[c*GW +: GW]), int'(NONE));
        for (int j = 0; j < N; j++) check_int("R1 count", int'(free_total[j*CW +: CW]), M);

        // R3: all invalid with small stamps, all queues free
        req_valid = '0; req_tl = '0; q_free = '1;
        run_slot("R3 invalid");

        // R6 tie: all stamps equal, everything valid, all free
        req_valid = '1; req_tl = '0; q_free = '1;
        run_slot("R6 tie");
        for (int j = 0; j < N; j++)
            check_int("R6 lowest input gets queue 1", int'(grant_code[(j*N)*GW +: GW]), 1);

        // R5/R10: input 2 most urgent everywhere, one free queue in row 0
        req_valid = '1;
        for (int c = 0; c < N*N; c++) req_tl[c*TL_W +: TL_W] = TL_W'(50 + (c % N) * 3);
        for (int j = 0; j < N; j++) req_tl[(j*N+2)*TL_W +: TL_W] = TL_W'(5);
        q_free = '1; q_free[0 +: M] = M'(3'b100);
        run_slot("R5 R10 urgent input");
        check_int("R5 single free goes to smallest", int'(grant_code[2*GW +: GW]), 3);
        check_int("R10 multi-output win", int'(grant_code[(1*N+2)*GW +: GW]), 1);

        // R9: change every input without strobe; outputs must hold
        begin
            logic [N*N*GW-1:0] held_code;
            logic [N*CW-1:0]   held_cnt;
            held_code = grant_code; held_cnt = free_total;
            req_valid = '0; req_tl = '1; q_free = '0;
            repeat (4) @(negedge clk);
            check_int("R9 valid stays low", int'(grant_valid), 0);
            for (int c = 0; c < N*N; c++)
                check_int("R9 code held", int'(grant_code[c*GW +: GW]), int'(held_code[c*GW +: GW]));
            for (int j = 0; j < N; j++)
                check_int("R9 count held", int'(free_total[j*CW +: CW]), int'(held_cnt[j*CW +: CW]));
        end

        // R4 R7 R8: sweep every availability mask against every valid mask
        for (int fm = 0; fm < (1 << M); fm++) begin
            for (int vm = 0; vm < (1 << N); vm++) begin
                for (int j = 0; j < N; j++) begin
                    q_free[j*M +: M] = M'(fm);
                    req_valid[j*N +: N] = N'(vm ^ (j * 5));
                    for (int i = 0; i < N; i++)
                        req_tl[(j*N+i)*TL_W +: TL_W] = TL_W'($urandom & 3);
                end
                run_slot("R4 R7 R8 sweep");
            end
        end

        // R5 R6 random traffic with narrow and wide stamp ranges
        for (int s = 0; s < 300; s++) begin
            rand_inputs(3, 70, 50);
            run_slot("R5 R6 narrow");
        end
        for (int s = 0; s < 300; s++) begin
            rand_inputs(255, 60, 60);
            run_slot("R5 R8 wide");
        end

        // back-to-back strobes: R2 each slot's table appears one cycle later
        for (int s = 0; s < 20; s++) begin
            rand_inputs(15, 80, 40);
            build_expect();
            slot_start = 1'b1;
            @(negedge clk);
            check_int("R2 back-to-back valid", int'(grant_valid), 1);
            check_table("R2 back-to-back");
        end
        slot_start = 1'b0;
        @(negedge clk);
        check_int("R2 drop after burst", int'(grant_valid), 0);

        // R1 reset again restores state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_int("R1 valid after reset", int'(grant_valid), 0);
        for (int c = 0; c < N*N; c++) check_int("R1 code after reset", int'(grant_code[c*GW +: GW]), int'(NONE));
        for (int j = 0; j < N; j++) check_int("R1 count after reset", int'(free_total[j*CW +: CW]), M);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule